// File: doc/BRIEF.md
# Byte-Loadable Address Generation Unit

This block holds the three 16-bit pointers of an 8-bit-bus microprogrammed machine: the program counter, the stack pointer and the memory address register. It is steered directly by the 31-bit control microword. The program counter and stack pointer are each reachable only one byte at a time. Separate microword bits load a high or low byte from the 8-bit internal bus, and separate bits drive a high or low byte back onto that bus. The program counter can also count up as a full 16-bit value.

The memory address register takes its value from the program counter, the stack pointer or the external H:L register pair through a four-way selector. The fourth choice selects nothing. The block also registers the memory read, memory write and memory-versus-I/O strobes from the microword. A registered flag reports when more than one byte driver was enabled onto the bus in the same cycle.

Top module: `addr_gen_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the program counter, stack pointer, memory address register, all three strobes and the conflict flag clear to zero.
- R2: Microword bit 22 loads `bus_in` into program counter bits 15:8 and bit 23 loads it into bits 7:0. Each byte is loaded independently, and the other byte keeps its value.
- R3: Microword bit 24, with neither program counter load bit set, adds one to the 16-bit program counter at the clock edge, wrapping from 16'hFFFF to 16'h0000.
- R4: When bit 24 is set together with bit 22 or bit 23, no increment occurs. Only the addressed byte or bytes change, and they take `bus_in`.
- R5: Microword bit 18 loads `bus_in` into stack pointer bits 15:8 and bit 19 loads it into bits 7:0. The stack pointer never counts.
- R6: Bits 16, 17, 20 and 21 drive, in the same cycle, the stack pointer high byte, stack pointer low byte, program counter high byte and program counter low byte onto `bus_out`. When none of them is set, `bus_out` is 8'h00 and `bus_oe` is 0. Otherwise `bus_oe` is 1.
- R7: With bit 27 set, the memory address register loads at the clock edge from the source named by {bit 26, bit 25}: 2'b00 selects the program counter, 2'b01 the stack pointer and 2'b10 `hl_in`. The pointer value used is the one held before that edge.
- R8: With bit 27 set and {bit 26, bit 25} = 2'b11, the memory address register keeps its value.
- R9: With bit 27 clear, the memory address register keeps its value whatever the select bits are.
- R10: `mem_rd`, `mem_wr` and `mem_sel` show microword bits 28, 29 and 30 one clock after they are applied. `mem_sel` is 1 for a memory access and 0 for I/O.
- R11: `bus_conflict` is 1 in the cycle after two or more of bits 16, 17, 20 and 21 were set together, and 0 after a cycle with one or none set.
- R12: When several byte drivers are enabled at once, `bus_out` is the bitwise OR of the enabled bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uword | input | 31 | Control microword; this block uses bits 16 to 30 |
| bus_in | input | 8 | Internal data bus value, used for byte loads |
| hl_in | input | 16 | H:L register pair, used as an address source |
| bus_out | output | 8 | Byte driven toward the internal bus |
| bus_oe | output | 1 | At least one byte driver is enabled |
| bus_conflict | output | 1 | Registered: more than one driver was enabled last cycle |
| pc | output | 16 | Program counter |
| sp | output | 16 | Stack pointer |
| mar | output | 16 | Memory address register |
| mem_rd | output | 1 | Registered memory read strobe |
| mem_wr | output | 1 | Registered memory write strobe |
| mem_sel | output | 1 | Registered memory (1) / I/O (0) select |

## Verification
The bench goes after the counter rollover from 16'hFFFF. A design that carried only within the low byte, or stopped at the top, would leave the wrong address after the wrap. It issues an increment together with a single byte load. A design that let the increment win, or carried into the loaded byte, would corrupt the pointer there. It also clocks the address register with the "none" select and checks that the value is held rather than zeroed or taken from a neighbouring source. Finally, it enables several byte drivers at once, and checks both the OR-ed bus value and the delayed conflict flag, which a design with the wrong delay or an off-by-one in the driver count would miss.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 2 * BYTE_W;
  localparam int UWORD_W = 31;

  // Microword bit positions (the control-word layout is decoded here)
  localparam int B_SP_OE_HI = 16;
  localparam int B_SP_OE_LO = 17;
  localparam int B_SP_LD_HI = 18;
  localparam int B_SP_LD_LO = 19;
  localparam int B_PC_OE_HI = 20;
  localparam int B_PC_OE_LO = 21;
  localparam int B_PC_LD_HI = 22;
  localparam int B_PC_LD_LO = 23;
  localparam int B_PC_INC   = 24;
  localparam int B_SEL_LSB  = 25;
  localparam int B_SEL_MSB  = 26;
  localparam int B_MAR_LD   = 27;
  localparam int B_MEM_RD   = 28;
  localparam int B_MEM_WR   = 29;
  localparam int B_MEM_SEL  = 30;

  localparam int N_DRV = 4;

  typedef enum logic [1:0] {
    SRC_PC   = 2'b00,
    SRC_SP   = 2'b01,
    SRC_HL   = 2'b10,
    SRC_NONE = 2'b11
  } mar_src_e;
endpackage

// File: rtl/agu_ptr_reg.sv
module agu_ptr_reg #(
  parameter int BYTE_W = agu_pkg::BYTE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ld_hi,
  input  logic                ld_lo,
  input  logic                inc,
  input  logic [BYTE_W-1:0]   din,
  output logic [2*BYTE_W-1:0] q,
  output logic [BYTE_W-1:0]   q_hi,
  output logic [BYTE_W-1:0]   q_lo
);
  localparam int W = 2 * BYTE_W;

  logic any_ld;
  assign any_ld = ld_hi | ld_lo;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (any_ld) begin
      if (ld_hi) q[W-1:BYTE_W]   <= din;
      if (ld_lo) q[BYTE_W-1:0]   <= din;
    end else if (inc) begin
      q <= q + W'(1);
    end
  end

  assign q_hi = q[W-1:BYTE_W];
  assign q_lo = q[BYTE_W-1:0];

  AST_INC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !any_ld) |=> (q == W'($past(q) + W'(1)))); // R3
  AST_LOAD_BEATS_INC: assert property (@(posedge clk) disable iff (rst)
    (inc && ld_lo && !ld_hi) |=> (q_lo == $past(din) && q_hi == $past(q_hi))); // R4
  AST_HI_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld_hi |=> (q_hi == $past(din))); // R2
endmodule

// File: rtl/agu_bus_mux.sv
module agu_bus_mux #(
  parameter int BYTE_W = agu_pkg::BYTE_W,
  parameter int N_SRC  = agu_pkg::N_DRV
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [N_SRC-1:0]              en,
  input  logic [N_SRC-1:0][BYTE_W-1:0]  src,
  output logic [BYTE_W-1:0]             bus_out,
  output logic                          bus_oe,
  output logic                          conflict
);
  localparam int CNT_W = $clog2(N_SRC + 1);

  logic [N_SRC-1:0][BYTE_W-1:0] acc;
  logic [N_SRC-1:0][CNT_W-1:0]  cnt;

  genvar i;
  generate
    for (i = 0; i < N_SRC; i++) begin : g_drv
      if (i == 0) begin : g_first
        assign acc[i] = en[i] ? src[i] : '0;
        assign cnt[i] = CNT_W'(en[i]);
      end else begin : g_rest
        assign acc[i] = acc[i-1] | (en[i] ? src[i] : '0);
        assign cnt[i] = cnt[i-1] + CNT_W'(en[i]);
      end
    end
  endgenerate

  assign bus_out = acc[N_SRC-1];
  assign bus_oe  = |en;

  always_ff @(posedge clk) begin
    if (rst) conflict <= 1'b0;
    else     conflict <= (cnt[N_SRC-1] > CNT_W'(1));
  end

  AST_CONFLICT_SEEN: assert property (@(posedge clk) disable iff (rst)
    ($countones(en) > 1) |=> conflict); // R11
  AST_CONFLICT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    ($countones(en) <= 1) |=> !conflict); // R11
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (rst)
    (en == '0) |-> (bus_out == '0 && !bus_oe)); // R6
endmodule

// File: rtl/agu_mar.sv
module agu_mar #(
  parameter int ADDR_W = agu_pkg::ADDR_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ld,
  input  agu_pkg::mar_src_e     sel,
  input  logic [ADDR_W-1:0]     pc,
  input  logic [ADDR_W-1:0]     sp,
  input  logic [ADDR_W-1:0]     hl,
  output logic [ADDR_W-1:0]     mar
);
  import agu_pkg::*;

  logic [ADDR_W-1:0] nxt;
  logic              take;

  always_comb begin
    take = ld;
    nxt  = mar;
    unique case (sel)
      SRC_PC:   nxt = pc;
      SRC_SP:   nxt = sp;
      SRC_HL:   nxt = hl;
      SRC_NONE: take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)       mar <= '0;
    else if (take) mar <= nxt;
  end

  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ld || sel == SRC_NONE) |=> $stable(mar)); // R8
  AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    (ld && sel == SRC_PC) |=> (mar == $past(pc))); // R7
endmodule

// File: rtl/addr_gen_unit.sv
module addr_gen_unit #(
  parameter int BYTE_W  = agu_pkg::BYTE_W,
  parameter int UWORD_W = agu_pkg::UWORD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [UWORD_W-1:0]    uword,
  input  logic [BYTE_W-1:0]     bus_in,
  input  logic [2*BYTE_W-1:0]   hl_in,
  output logic [BYTE_W-1:0]     bus_out,
  output logic                  bus_oe,
  output logic                  bus_conflict,
  output logic [2*BYTE_W-1:0]   pc,
  output logic [2*BYTE_W-1:0]   sp,
  output logic [2*BYTE_W-1:0]   mar,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  mem_sel
);
  import agu_pkg::*;

  localparam int AW = 2 * BYTE_W;

  logic [BYTE_W-1:0] pc_hi, pc_lo, sp_hi, sp_lo;
  logic [N_DRV-1:0]              drv_en;
  logic [N_DRV-1:0][BYTE_W-1:0]  drv_src;
  mar_src_e                      msel;

  agu_ptr_reg #(.BYTE_W(BYTE_W)) u_pc (
    .clk(clk), .rst(rst),
    .ld_hi(uword[B_PC_LD_HI]), .ld_lo(uword[B_PC_LD_LO]),
    .inc(uword[B_PC_INC]), .din(bus_in),
    .q(pc), .q_hi(pc_hi), .q_lo(pc_lo)
  );

  agu_ptr_reg #(.BYTE_W(BYTE_W)) u_sp (
    .clk(clk), .rst(rst),
    .ld_hi(uword[B_SP_LD_HI]), .ld_lo(uword[B_SP_LD_LO]),
    .inc(1'b0), .din(bus_in),
    .q(sp), .q_hi(sp_hi), .q_lo(sp_lo)
  );

  assign drv_en  = {uword[B_PC_OE_LO], uword[B_PC_OE_HI],
                    uword[B_SP_OE_LO], uword[B_SP_OE_HI]};
  assign drv_src = {pc_lo, pc_hi, sp_lo, sp_hi};

  agu_bus_mux #(.BYTE_W(BYTE_W), .N_SRC(N_DRV)) u_bus (
    .clk(clk), .rst(rst), .en(drv_en), .src(drv_src),
    .bus_out(bus_out), .bus_oe(bus_oe), .conflict(bus_conflict)
  );

  assign msel = mar_src_e'({uword[B_SEL_MSB], uword[B_SEL_LSB]});

  agu_mar #(.ADDR_W(AW)) u_mar (
    .clk(clk), .rst(rst), .ld(uword[B_MAR_LD]), .sel(msel),
    .pc(pc), .sp(sp), .hl(hl_in), .mar(mar)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_rd  <= 1'b0;
      mem_wr  <= 1'b0;
      mem_sel <= 1'b0;
    end else begin
      mem_rd  <= uword[B_MEM_RD];
      mem_wr  <= uword[B_MEM_WR];
      mem_sel <= uword[B_MEM_SEL];
    end
  end

  AST_RD_DELAY: assert property (@(posedge clk) disable iff (rst)
    uword[B_MEM_RD] |=> mem_rd); // R10
  AST_SP_STILL: assert property (@(posedge clk) disable iff (rst)
    (!uword[B_SP_LD_HI] && !uword[B_SP_LD_LO]) |=> $stable(sp)); // R5
endmodule

// File: tb/test_addr_gen_unit.sv
module test_addr_gen_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [30:0] uword = '0;
  logic [7:0]  bus_in = '0;
  logic [15:0] hl_in = '0;
  logic [7:0]  bus_out;
  logic        bus_oe, bus_conflict, mem_rd, mem_wr, mem_sel;
  logic [15:0] pc, sp, mar;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  logic [15:0] m_pc = '0, m_sp = '0, m_mar = '0;
  logic        m_rd = 0, m_wr = 0, m_ms = 0, m_cf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_gen_unit i_addr_gen_unit (
    .clk(clk), .rst(rst), .uword(uword), .bus_in(bus_in), .hl_in(hl_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_conflict(bus_conflict),
    .pc(pc), .sp(sp), .mar(mar),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_sel(mem_sel)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [30:0] uw, input logic [7:0] b, input logic [15:0] h);
    logic [7:0]  eb;
    int          n;
    logic [15:0] npc, nsp, nmar;
    @(negedge clk);
    uword = uw; bus_in = b; hl_in = h;
    #1;
    eb = '0; n = 0;
    if (uw[16]) begin eb |= m_sp[15:8]; n++; end
    if (uw[17]) begin eb |= m_sp[7:0];  n++; end
    if (uw[20]) begin eb |= m_pc[15:8]; n++; end
    if (uw[21]) begin eb |= m_pc[7:0];  n++; end
    chk("R6 R12 bus_out", {8'h00, bus_out}, {8'h00, eb});
    chk("R6 bus_oe", {15'h0, bus_oe}, {15'h0, n > 0});
    npc = m_pc;
    if (uw[22] || uw[23]) begin
      if (uw[22]) npc[15:8] = b;
      if (uw[23]) npc[7:0]  = b;
    end else if (uw[24]) npc = m_pc + 16'd1;
    nsp = m_sp;
    if (uw[18]) nsp[15:8] = b;
    if (uw[19]) nsp[7:0]  = b;
    nmar = m_mar;
    if (uw[27]) begin
      case (uw[26:25])
        2'b00: nmar = m_pc;
        2'b01: nmar = m_sp;
        2'b10: nmar = h;
        default: nmar = m_mar;
      endcase
    end
    @(posedge clk);
    m_pc = npc; m_sp = nsp; m_mar = nmar;
    m_rd = uw[28]; m_wr = uw[29]; m_ms = uw[30]; m_cf = (n > 1);
    #1;
    chk("R2 R3 R4 pc", pc, m_pc);
    chk("R5 sp", sp, m_sp);
    chk("R7 R8 R9 mar", mar, m_mar);
    chk("R10 strobes", {13'h0, mem_rd, mem_wr, mem_sel}, {13'h0, m_rd, m_wr, m_ms});
    chk("R11 conflict", {15'h0, bus_conflict}, {15'h0, m_cf});
  endtask

  function automatic logic [30:0] bits(input int a, input int b2 = -1, input int c = -1);
    logic [30:0] w = '0;
    w[a] = 1'b1;
    if (b2 >= 0) w[b2] = 1'b1;
    if (c >= 0)  w[c]  = 1'b1;
    return w;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1 pc", pc, 16'h0);
    chk("R1 sp", sp, 16'h0);
    chk("R1 mar", mar, 16'h0);
    chk("R1 flags", {12'h0, mem_rd, mem_wr, mem_sel, bus_conflict}, 16'h0);
    @(negedge clk); rst = 1'b0;

    // R2: independent byte loads; R3 wrap
    step(bits(22), 8'hFF, 16'h0);
    step(bits(23), 8'hFE, 16'h0);
    step(bits(24), 8'h00, 16'h0);              // FFFF
    step(bits(24), 8'h00, 16'h0);              // wraps to 0000 (R3)
    step(bits(24), 8'h00, 16'h0);
    // R4: increment with low-byte load
    step(bits(23, 24), 8'hFF, 16'h0);
    step(bits(22, 24), 8'h12, 16'h0);
    // R5: stack pointer bytes, incr bit ignored for sp
    step(bits(18), 8'hA5, 16'h0);
    step(bits(19), 8'h3C, 16'h0);
    // R6: single drivers
    step(bits(16), 8'h00, 16'h0);
    step(bits(17), 8'h00, 16'h0);
    step(bits(20), 8'h00, 16'h0);
    step(bits(21), 8'h00, 16'h0);
    // R12 / R11: several drivers at once
    step(bits(16, 21), 8'h00, 16'h0);
    step(bits(17, 20, 21), 8'h00, 16'h0);
    step(31'h0, 8'h00, 16'h0);
    // R7: each source
    step(bits(27), 8'h00, 16'hBEEF);
    step(bits(27, 25), 8'h00, 16'hBEEF);
    step(bits(27, 26), 8'h00, 16'hBEEF);
    // R8: none source with clock
    step(bits(27, 25, 26), 8'h00, 16'h1234);
    // R9: select without clock
    step(bits(25), 8'h00, 16'h5678);
    step(bits(26), 8'h00, 16'h5678);
    // R10: strobes
    step(bits(28, 30), 8'h00, 16'h0);
    step(bits(29), 8'h00, 16'h0);
    step(31'h0, 8'h00, 16'h0);

    for (int k = 0; k < 400; k++)
      step(31'($urandom()), 8'($urandom()), 16'($urandom()));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule